// File: doc/BRIEF.md
# Command macro processor core

This block is a small programmable sequencer. A command-stream engine starts it to run a short uploaded program. The program turns a list of input words into a series of method writes, each an address and data pair, aimed at the engine's register file. The core reads 32-bit instruction words from a code port one word per cycle. It works on eight 32-bit registers. It pulls input words from a parameter queue, can read engine registers through a request port, and sends method writes through a second port. Both ports use valid/ready handshakes.

Each instruction computes a result with one of six operations: ALU, add-immediate, three bitfield forms, or register read. Branches are a separate operation. A 3-bit result code then decides how the result is used. It can write a register, fetch a parameter, load the method address, and send a word, in fixed combinations. Branches and exit have a delay slot. A branch can also annul its delay slot. Each send auto-increments the method address. The core pulses `done` after the exit sequence. It raises a sticky `error` on malformed programs or parameter misuse.

Top module: `mp_core`

## Requirements
- R1: A `start` pulse while idle clears all registers and sets the program counter to 0. It pops the head of the parameter queue into register 1 and raises `busy`. Later fetches then take the second and following words. Starting with an empty queue raises `error` and does not run.
- R2: Instruction fields are: operation [2:0], result code [6:4], exit [7], destination [10:8], source A [13:11], source B [16:14], signed immediate [31:14], ALU function [21:17]. ALU functions are 0 add, 2 A-B, 8 xor, 9 or, 10 and, 11 A&~B, 12 ~(A&B).
- R3: Operation 1 gives A+immediate. Operation 5 requests an engine register at the low address bits of A+immediate and stalls until `rd_ready`. The returned word becomes the result. A read request and a method write are never offered in the same cycle.
- R4: The bitfield operations use mask (1<<size)-1. Size is [26:22], source position is [21:17] and destination position is [31:27]. Operation 2 inserts (B>>src)&mask into A at the destination position. Operation 3 gives ((B>>A)&mask)<<dst. Operation 4 gives ((B>>src)&mask)<<A.
- R5: Result codes are as follows. 0: fetch into dst. 1: move. 2: move and set address. 3: fetch into dst and send result. 4: move and send. 5: fetch into dst and set address. 6: move, set address, then send a fetched word. 7: move, set address, then send result bits [17:12].
- R6: Register 0 reads as zero and ignores writes.
- R7: The method address loads bits [11:0] of a result as the address and bits [17:12] as the step. Each send goes to the current address, and the address then advances by the step. A send holds `mw_valid` and its address until `mw_ready`, and it is written exactly once.
- R8: A branch (operation 7) tests A against zero when bit 4 is 0, or against nonzero when bit 4 is 1. Its target is its own word address plus the immediate. When taken, the next instruction runs as a delay slot before the jump. When not taken, execution falls through.
- R9: A taken branch with bit 5 set jumps at once and skips the delay slot.
- R10: An instruction with the exit flag is followed by one more instruction, then the core stops and pulses `done` with `busy` low. If the exit sits in a branch delay slot, that final instruction is the branch target. An exit flag on a taken branch has no effect.
- R11: `error` rises and the run stops on any of these: operation 6, an ALU function outside the listed set, a branch in a delay slot, or a fetch from an empty queue. `error` also rises together with `done` when queue words remain at exit. It stays high until the next start.
- R12: `imem_addr` presents the program counter, and the word on `imem_data` is used in the same cycle. An instruction without handshakes completes in one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a program run (accepted when idle) |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| error | output | 1 | Sticky fault flag, cleared by start |
| imem_addr | output | PC_W | Code word address |
| imem_data | input | 32 | Code word at imem_addr |
| prm_valid | input | 1 | Parameter queue is not empty |
| prm_data | input | 32 | Head word of the parameter queue |
| prm_ready | output | 1 | Pop the head word |
| mw_valid | output | 1 | Method write offered |
| mw_addr | output | MA_W | Method write address |
| mw_data | output | 32 | Method write data |
| mw_ready | input | 1 | Method write accepted |
| rd_valid | output | 1 | Engine register read requested |
| rd_addr | output | MA_W | Engine register read address |
| rd_data | input | 32 | Read data, valid with rd_ready |
| rd_ready | input | 1 | Read completed |

## Verification
A method write shows on the sink at the same clock edge at which its instruction completes. `done` comes two edges after the exit slot completes: one edge to finish the slot and one to test the queue for leftover words. Fault errors appear one edge after the faulting instruction is presented. The bench logs every write accepted at a rising edge and samples `done`, `error` and `busy` at falling edges. It waits for `done` or `error`, then compares the whole write log, so it never depends on counting cycles inside a program. The read responder and the write sink are throttled in some tests to prove that stalls neither drop nor repeat a write.

// File: rtl/mp_pkg.sv
package mp_pkg;
  localparam int unsigned DW = 32;

  typedef enum logic [2:0] {
    OP_ALU = 3'd0, OP_ADDI = 3'd1, OP_BFI = 3'd2, OP_XSA = 3'd3,
    OP_XSL = 3'd4, OP_READ = 3'd5, OP_BAD = 3'd6, OP_BRA = 3'd7
  } op_e;

  // ALU function legality: carry/borrow forms and 4..7, 13..31 rejected
  function automatic logic alu_ok(input logic [4:0] f);
    case (f)
      5'd0, 5'd2, 5'd8, 5'd9, 5'd10, 5'd11, 5'd12: alu_ok = 1'b1;
      default: alu_ok = 1'b0;
    endcase
  endfunction

  function automatic logic [DW-1:0] alu_calc(input logic [4:0] f,
                                             input logic [DW-1:0] a,
                                             input logic [DW-1:0] b);
    case (f)
      5'd0:    alu_calc = a + b;
      5'd2:    alu_calc = a - b;
      5'd8:    alu_calc = a ^ b;
      5'd9:    alu_calc = a | b;
      5'd10:   alu_calc = a & b;
      5'd11:   alu_calc = a & ~b;
      5'd12:   alu_calc = ~(a & b);
      default: alu_calc = '0;
    endcase
  endfunction

  function automatic logic [DW-1:0] fmask(input logic [4:0] sz);
    fmask = (DW'(1) << sz) - DW'(1);
  endfunction

  function automatic logic [DW-1:0] f_insert(input logic [DW-1:0] a,
                                             input logic [DW-1:0] b,
                                             input logic [4:0] sp,
                                             input logic [4:0] sz,
                                             input logic [4:0] dp);
    logic [DW-1:0] m;
    m = fmask(sz);
    f_insert = (a & ~(m << dp)) | (((b >> sp) & m) << dp);
  endfunction
endpackage

// File: rtl/mp_regfile.sv
module mp_regfile #(
  parameter int NREG = 8,
  parameter int W    = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd,
  input  logic [AW-1:0] ra,
  input  logic [AW-1:0] rb,
  output logic [W-1:0]  qa,
  output logic [W-1:0]  qb
);
  logic [W-1:0] rf [NREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
    end else begin
      if (clr) begin
        for (int i = 0; i < NREG; i++) rf[i] <= '0;
      end
      if (we && wa != '0) rf[wa] <= wd;
    end
  end

  // entry 0 is never written; reads of it are forced to zero as well
  assign qa = (ra == '0) ? '0 : rf[ra];
  assign qb = (rb == '0) ? '0 : rf[rb];
endmodule

// File: rtl/mp_exec.sv
module mp_exec
  import mp_pkg::*;
#(
  parameter int PC_W = 8
) (
  input  logic [31:0]   instr,
  input  logic [DW-1:0] qa,
  input  logic [DW-1:0] qb,
  input  logic [DW-1:0] rdq,
  input  logic [PC_W-1:0] pc,
  output logic [DW-1:0] res,
  output logic [DW-1:0] rd_full,
  output logic          is_br,
  output logic          need_rd,
  output logic          taken,
  output logic          annul,
  output logic [PC_W-1:0] tgt,
  output logic          bad
);
  op_e           op;
  logic [4:0]    fsb, fsz, fdp;
  logic [DW-1:0] imm;

  assign op  = op_e'(instr[2:0]);
  assign fsb = instr[21:17];
  assign fsz = instr[26:22];
  assign fdp = instr[31:27];
  assign imm = {{(DW-18){instr[31]}}, instr[31:14]};

  assign is_br   = (op == OP_BRA);
  assign need_rd = (op == OP_READ);
  assign rd_full = qa + imm;
  assign annul   = instr[5];
  assign taken   = instr[4] ? (qa != '0) : (qa == '0);
  assign tgt     = pc + imm[PC_W-1:0];
  assign bad     = (op == OP_BAD) || (op == OP_ALU && !alu_ok(fsb));

  always_comb begin
    case (op)
      OP_ALU:  res = alu_calc(fsb, qa, qb);
      OP_ADDI: res = qa + imm;
      OP_BFI:  res = f_insert(qa, qb, fsb, fsz, fdp);
      OP_XSA:  res = ((qb >> qa) & fmask(fsz)) << fdp;
      OP_XSL:  res = ((qb >> fsb) & fmask(fsz)) << qa;
      OP_READ: res = rdq;
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/mp_core.sv
module mp_core
  import mp_pkg::*;
#(
  parameter int PC_W  = 8,
  parameter int MA_W  = 12,
  parameter int INC_W = 6,
  parameter int NREG  = 8,
  localparam int RAW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  output logic            busy,
  output logic            done,
  output logic            error,
  output logic [PC_W-1:0] imem_addr,
  input  logic [31:0]     imem_data,
  input  logic            prm_valid,
  input  logic [31:0]     prm_data,
  output logic            prm_ready,
  output logic            mw_valid,
  output logic [MA_W-1:0] mw_addr,
  output logic [31:0]     mw_data,
  input  logic            mw_ready,
  output logic            rd_valid,
  output logic [MA_W-1:0] rd_addr,
  input  logic [31:0]     rd_data,
  input  logic            rd_ready
);
  // run state
  logic            running, chk_q, done_q, err_q;
  logic [PC_W-1:0] pc, dly_tgt;
  logic            dly_v, exit_p;
  logic [MA_W-1:0] maddr;
  logic [INC_W-1:0] minc;
  logic            rd_have;
  logic [DW-1:0]   rd_q;

  // decode / execute
  logic [DW-1:0]   qa, qb, res, rd_full;
  logic            is_br, need_rd, taken, annul, bad;
  logic [PC_W-1:0] tgt;
  logic [2:0]      rop;
  logic            ex_flag;

  assign rop     = imem_data[6:4];
  assign ex_flag = imem_data[7];

  mp_exec #(.PC_W(PC_W)) u_exec (
    .instr(imem_data), .qa(qa), .qb(qb), .rdq(rd_q), .pc(pc),
    .res(res), .rd_full(rd_full), .is_br(is_br), .need_rd(need_rd),
    .taken(taken), .annul(annul), .tgt(tgt), .bad(bad)
  );

  // result-code decode (suppressed on branches)
  logic do_fetch, wr_par, do_set, do_send, send_par, send_hi;
  always_comb begin
    wr_par   = !is_br && (rop == 3'd0 || rop == 3'd3 || rop == 3'd5);
    send_par = !is_br && (rop == 3'd6);
    send_hi  = !is_br && (rop == 3'd7);
    do_fetch = wr_par || send_par;
    do_set   = !is_br && (rop == 3'd2 || rop == 3'd5 || rop == 3'd6 || rop == 3'd7);
    do_send  = !is_br && (rop == 3'd3 || rop == 3'd4 || rop == 3'd6 || rop == 3'd7);
  end

  // named internal events
  logic in_slot, fault, rd_ok, commit, finish, start_acc, br_jump, br_dly;
  assign in_slot   = dly_v || exit_p;
  assign fault     = running && (bad || (is_br && in_slot) || (do_fetch && !prm_valid));
  assign rd_ok     = !need_rd || rd_have;
  assign commit    = running && !fault && rd_ok && (!do_send || mw_ready);
  assign finish    = commit && exit_p;
  assign start_acc = start && !running && !chk_q;
  assign br_jump   = commit && is_br && taken && annul;
  assign br_dly    = commit && is_br && taken && !annul;

  // register file write port: start loads r1, otherwise commit writes dst
  logic           rf_we, rf_clr;
  logic [RAW-1:0] rf_wa;
  logic [DW-1:0]  rf_wd;
  assign rf_clr = start_acc;
  assign rf_we  = start_acc ? prm_valid : (commit && !is_br);
  assign rf_wa  = start_acc ? RAW'(1) : imem_data[8 +: RAW];
  assign rf_wd  = (start_acc || wr_par) ? prm_data : res;

  mp_regfile #(.NREG(NREG), .W(DW)) u_rf (
    .clk(clk), .rst_n(rst_n), .clr(rf_clr), .we(rf_we), .wa(rf_wa), .wd(rf_wd),
    .ra(imem_data[11 +: RAW]), .rb(imem_data[14 +: RAW]), .qa(qa), .qb(qb)
  );

  // ports
  logic [MA_W-1:0]  set_addr;
  logic [INC_W-1:0] set_inc;
  assign set_addr  = res[MA_W-1:0];
  assign set_inc   = res[MA_W +: INC_W];

  assign imem_addr = pc;
  assign prm_ready = (start_acc && prm_valid) || (commit && do_fetch);
  assign rd_valid  = running && !fault && need_rd && !rd_have;
  assign rd_addr   = rd_full[MA_W-1:0];
  assign mw_valid  = running && !fault && do_send && rd_ok;
  assign mw_addr   = do_set ? set_addr : maddr;
  assign mw_data   = send_par ? prm_data : (send_hi ? DW'(set_inc) : res);
  assign busy      = running || chk_q;
  assign done      = done_q;
  assign error     = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0; chk_q <= 1'b0; done_q <= 1'b0; err_q <= 1'b0;
      pc <= '0; dly_tgt <= '0; dly_v <= 1'b0; exit_p <= 1'b0;
      maddr <= '0; minc <= '0; rd_have <= 1'b0; rd_q <= '0;
    end else begin
      done_q <= chk_q;
      chk_q  <= 1'b0;
      if (chk_q && prm_valid) err_q <= 1'b1;
      if (start_acc) begin
        running <= prm_valid;
        err_q   <= !prm_valid;
        pc <= '0; dly_v <= 1'b0; exit_p <= 1'b0;
        maddr <= '0; minc <= '0; rd_have <= 1'b0;
      end else if (fault) begin
        running <= 1'b0;
        err_q   <= 1'b1;
      end else begin
        if (rd_valid && rd_ready) begin
          rd_have <= 1'b1;
          rd_q    <= rd_data;
        end
        if (commit) begin
          rd_have <= 1'b0;
          if (do_set) begin
            minc  <= set_inc;
            maddr <= do_send ? set_addr + MA_W'(set_inc) : set_addr;
          end else if (do_send) begin
            maddr <= maddr + MA_W'(minc);
          end
          if (finish) begin
            running <= 1'b0;
            chk_q   <= 1'b1;
          end else begin
            if (ex_flag && !(is_br && taken)) exit_p <= 1'b1;
            if (br_jump) begin
              pc <= tgt;
            end else if (br_dly) begin
              pc <= pc + 1'b1; dly_v <= 1'b1; dly_tgt <= tgt;
            end else if (dly_v) begin
              pc <= dly_tgt; dly_v <= 1'b0;
            end else begin
              pc <= pc + 1'b1;
            end
          end
        end
      end
    end
  end

  // ---------------- assertions ----------------
  assert_pop_nonempty_R11: assert property (@(posedge clk) disable iff (!rst_n)
    prm_ready |-> prm_valid);

  assert_mw_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mw_valid && !mw_ready) |=> (mw_valid && $stable(mw_addr)));

  assert_one_port_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_valid, mw_valid}));

  assert_slot_branch_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (running && is_br && in_slot) |=> (error && !busy));

  assert_annul_jump_R9: assert property (@(posedge clk) disable iff (!rst_n)
    br_jump |=> (imem_addr == $past(tgt)));

  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_start_pc_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (start_acc && prm_valid) |=> (busy && imem_addr == '0));
endmodule

// File: tb/tb_mp_core.sv
module tb_mp_core;
  localparam int PC_W = 8;
  localparam int MA_W = 12;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic busy, done, error, prm_ready, mw_valid, rd_valid;
  logic [PC_W-1:0] imem_addr;
  logic [31:0] imem_data, prm_data, mw_data, rd_data;
  logic [MA_W-1:0] mw_addr, rd_addr;
  logic prm_valid, mw_ready, rd_ready;

  always #10 clk = ~clk;   // 50 MHz

  mp_core #(.PC_W(PC_W), .MA_W(MA_W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .error(error),
    .imem_addr(imem_addr), .imem_data(imem_data),
    .prm_valid(prm_valid), .prm_data(prm_data), .prm_ready(prm_ready),
    .mw_valid(mw_valid), .mw_addr(mw_addr), .mw_data(mw_data), .mw_ready(mw_ready),
    .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_data(rd_data), .rd_ready(rd_ready)
  );

  // code memory, parameter queue, write sink, read responder
  logic [31:0] prog [64];
  logic [31:0] q [64];
  int head = 0, tail = 0, nlog = 0, cyc = 0;
  logic flush = 1'b0, mw_alt = 1'b0, rdy_r = 1'b0;
  logic [MA_W-1:0] la [128];
  logic [31:0]     ld [128];

  assign imem_data = prog[imem_addr[5:0]];
  assign prm_valid = head < tail;
  assign prm_data  = q[head[5:0]];
  assign mw_ready  = mw_alt ? cyc[0] : 1'b1;
  assign rd_ready  = rdy_r;
  assign rd_data   = 32'h5A5A_0000 ^ {20'd0, rd_addr};

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (flush) head <= tail;
    else if (prm_ready && head < tail) head <= head + 1;
    if (mw_valid && mw_ready) begin
      la[nlog[6:0]] <= mw_addr;
      ld[nlog[6:0]] <= mw_data;
      nlog <= nlog + 1;
    end
    rdy_r <= rd_valid && !rdy_r;
  end

  int n_chk = 0, n_bad = 0, base = 0, n_exp = 0;
  logic [MA_W-1:0] ea [32];
  logic [31:0]     ed [32];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // instruction builders
  function automatic logic [31:0] i_alu(input logic [2:0] rop, input logic [2:0] d,
      input logic [2:0] a, input logic [2:0] b, input logic [4:0] f, input logic ex);
    return {10'd0, f, b, a, d, ex, rop, 1'b0, 3'd0};
  endfunction
  function automatic logic [31:0] i_imm(input logic [2:0] op, input logic [2:0] rop,
      input logic [2:0] d, input logic [2:0] a, input logic [17:0] imm, input logic ex);
    return {imm, a, d, ex, rop, 1'b0, op};
  endfunction
  function automatic logic [31:0] i_bf(input logic [2:0] op, input logic [2:0] d,
      input logic [2:0] a, input logic [2:0] b, input logic [4:0] sp,
      input logic [4:0] sz, input logic [4:0] dp);
    return {dp, sz, sp, b, a, d, 1'b0, 3'd4, 1'b0, op};
  endfunction
  function automatic logic [31:0] i_br(input logic [2:0] a, input logic nz,
      input logic an, input logic [17:0] imm);
    return {imm, a, 3'd0, 1'b0, 1'b0, an, nz, 1'b0, 3'd7};
  endfunction
  function automatic logic [31:0] ref_alu(input int f, input logic [31:0] a, input logic [31:0] b);
    case (f)
      0: return a + b;   2: return a - b;   8: return a ^ b;
      9: return a | b;   10: return a & b;  11: return a & ~b;
      default: return ~(a & b);
    endcase
  endfunction

  task automatic new_test(input bit alt);
    @(negedge clk) flush = 1'b1;
    @(negedge clk) flush = 1'b0;
    mw_alt = alt;
    n_exp = 0;
    for (int i = 0; i < 64; i++) prog[i] = i_imm(3'd1, 3'd4, 3'd0, 3'd0, 18'h0BAD, 1'b0);
  endtask
  task automatic push(input logic [31:0] v);
    q[tail[5:0]] = v; tail = tail + 1;
  endtask
  task automatic expw(input logic [MA_W-1:0] a, input logic [31:0] d);
    ea[n_exp] = a; ed[n_exp] = d; n_exp++;
  endtask
  task automatic run(output bit dn, output bit er);
    dn = 0; er = 0;
    base = nlog;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    for (int c = 0; c < 3000 && !dn && !er; c++) begin
      dn = done; er = error;
      if (!dn && !er) @(negedge clk);
    end
  endtask
  task automatic cmp_log(input string req);
    check({req, " write count"}, nlog - base, n_exp);
    for (int i = 0; i < n_exp && i < nlog - base; i++) begin
      check({req, " addr"}, {20'd0, la[(base + i) % 128]}, {20'd0, ea[i]});
      check({req, " data"}, ld[(base + i) % 128], ed[i]);
    end
  endtask

  // R1 R5 R6 R7 R12: basic sends, first parameter in r1
  task automatic t_basic;
    bit dn, er;
    new_test(1'b0);
    push(32'h1234); push(32'h55);
    prog[0] = i_imm(3'd1, 3'd2, 3'd2, 3'd0, 18'h01010, 1'b0);
    prog[1] = i_alu(3'd4, 3'd3, 3'd1, 3'd0, 5'd0, 1'b0);
    prog[2] = i_alu(3'd3, 3'd4, 3'd1, 3'd1, 5'd0, 1'b0);
    prog[3] = i_alu(3'd4, 3'd5, 3'd4, 3'd0, 5'd0, 1'b1);
    prog[4] = i_imm(3'd1, 3'd4, 3'd0, 3'd0, 18'h7, 1'b0);
    expw(12'h010, 32'h1234); expw(12'h011, 32'h2468);
    expw(12'h012, 32'h55);   expw(12'h013, 32'h7);
    run(dn, er);
    check("R1 done", dn, 1); check("R11 no error", er, 0);
    check("R10 idle after done", busy, 0);
    cmp_log("R1/R5/R7");
  endtask

  // R2: each ALU function
  task automatic t_alu;
    bit dn, er;
    int fs[7] = '{0, 2, 8, 9, 10, 11, 12};
    logic [31:0] a = 32'hF0F0_1234, b = 32'h0FF0_00FF;
    new_test(1'b0);
    push(a); push(b);
    prog[0] = i_imm(3'd1, 3'd2, 3'd7, 3'd0, 18'h01100, 1'b0);
    prog[1] = i_alu(3'd0, 3'd2, 3'd0, 3'd0, 5'd0, 1'b0);
    for (int i = 0; i < 7; i++) begin
      prog[2 + i] = i_alu(3'd4, 3'd3, 3'd1, 3'd2, fs[i][4:0], i == 6);
      expw(12'h100 + 12'(i), ref_alu(fs[i], a, b));
    end
    prog[9] = i_alu(3'd1, 3'd0, 3'd0, 3'd0, 5'd0, 1'b0);
    run(dn, er);
    check("R2 done", dn, 1); check("R2 no error", er, 0);
    cmp_log("R2");
  endtask

  // R3 R4 R6: immediate add, bitfields, read, zero register; throttled sink
  task automatic t_bits;
    bit dn, er;
    new_test(1'b1);
    push(32'hABCD_1234);
    prog[0] = i_imm(3'd1, 3'd2, 3'd7, 3'd0, 18'h02200, 1'b0);
    prog[1] = i_imm(3'd1, 3'd1, 3'd2, 3'd0, 18'h3FFFD, 1'b0);
    prog[2] = i_bf(3'd2, 3'd3, 3'd2, 3'd1, 5'd4, 5'd8, 5'd12);
    prog[3] = i_imm(3'd1, 3'd1, 3'd4, 3'd0, 18'h8, 1'b0);
    prog[4] = i_bf(3'd3, 3'd5, 3'd4, 3'd1, 5'd0, 5'd8, 5'd4);
    prog[5] = i_bf(3'd4, 3'd5, 3'd4, 3'd1, 5'd16, 5'd4, 5'd0);
    prog[6] = i_imm(3'd5, 3'd4, 3'd6, 3'd4, 18'h30, 1'b0);
    prog[7] = i_imm(3'd1, 3'd4, 3'd0, 3'd2, 18'h1, 1'b1);
    prog[8] = i_imm(3'd1, 3'd4, 3'd0, 3'd0, 18'h11, 1'b0);
    expw(12'h200, 32'hFFF2_3FFD); expw(12'h202, 32'h120);
    expw(12'h204, 32'hD00);       expw(12'h206, 32'h5A5A_0038);
    expw(12'h208, 32'hFFFF_FFFE); expw(12'h20A, 32'h11);
    run(dn, er);
    check("R3 done", dn, 1); check("R4 no error", er, 0);
    cmp_log("R3/R4/R6/R7");
  endtask

  // R5: result codes 5, 6, 7 and fetch-and-send
  task automatic t_rops;
    bit dn, er;
    new_test(1'b0);
    push(32'h77); push(32'h1111); push(32'h2222); push(32'h3333);
    prog[0] = i_imm(3'd1, 3'd5, 3'd2, 3'd0, 18'h01300, 1'b0);
    prog[1] = i_imm(3'd1, 3'd6, 3'd3, 3'd0, 18'h01310, 1'b0);
    prog[2] = i_alu(3'd4, 3'd4, 3'd2, 3'd3, 5'd0, 1'b0);
    prog[3] = i_imm(3'd1, 3'd7, 3'd5, 3'd0, 18'h02320, 1'b1);
    prog[4] = i_alu(3'd3, 3'd6, 3'd1, 3'd0, 5'd0, 1'b0);
    expw(12'h310, 32'h2222); expw(12'h311, 32'h2421);
    expw(12'h320, 32'h2);    expw(12'h322, 32'h77);
    run(dn, er);
    check("R5 done", dn, 1); check("R5 all params used", er, 0);
    cmp_log("R5");
  endtask

  // R8 R9 R10: counted loop with delay slot, annulled branch, exit slot
  task automatic t_branch;
    bit dn, er;
    new_test(1'b0);
    push(32'd3);
    prog[0] = i_imm(3'd1, 3'd2, 3'd7, 3'd0, 18'h01400, 1'b0);
    prog[1] = i_alu(3'd4, 3'd0, 3'd1, 3'd0, 5'd0, 1'b0);
    prog[2] = i_imm(3'd1, 3'd1, 3'd1, 3'd1, 18'h3FFFF, 1'b0);
    prog[3] = i_br(3'd1, 1'b1, 1'b0, 18'h3FFFE);
    prog[4] = i_imm(3'd1, 3'd4, 3'd0, 3'd0, 18'h99, 1'b0);
    prog[5] = i_br(3'd1, 1'b0, 1'b1, 18'h3);
    prog[8] = i_imm(3'd1, 3'd4, 3'd0, 3'd0, 18'h55, 1'b1);
    prog[9] = i_imm(3'd1, 3'd4, 3'd0, 3'd0, 18'h66, 1'b0);
    expw(12'h400, 3); expw(12'h401, 32'h99); expw(12'h402, 2); expw(12'h403, 32'h99);
    expw(12'h404, 1); expw(12'h405, 32'h99); expw(12'h406, 32'h55); expw(12'h407, 32'h66);
    run(dn, er);
    check("R8 done", dn, 1); check("R9 no error", er, 0);
    cmp_log("R8/R9/R10");
  endtask

  // R10: exit placed in a branch delay slot runs the target then stops
  task automatic t_exit_slot;
    bit dn, er;
    new_test(1'b0);
    push(32'd0);
    prog[0] = i_imm(3'd1, 3'd2, 3'd7, 3'd0, 18'h01500, 1'b0);
    prog[1] = i_br(3'd0, 1'b0, 1'b0, 18'h4);
    prog[2] = i_imm(3'd1, 3'd4, 3'd0, 3'd0, 18'hA1, 1'b1);
    prog[5] = i_imm(3'd1, 3'd4, 3'd0, 3'd0, 18'hB2, 1'b0);
    prog[6] = i_imm(3'd1, 3'd4, 3'd0, 3'd0, 18'hC3, 1'b0);
    expw(12'h500, 32'hA1); expw(12'h501, 32'hB2);
    run(dn, er);
    check("R10 exit-in-slot done", dn, 1); check("R10 no error", er, 0);
    cmp_log("R10");
  endtask

  // R11: each fault condition
  task automatic t_err(input string tag, input int kind);
    bit dn, er;
    new_test(1'b0);
    if (kind != 5) push(32'h1);
    if (kind == 3) push(32'h2);
    case (kind)
      0: prog[0] = 32'h0000_0006;
      1: prog[0] = i_alu(3'd4, 3'd1, 3'd1, 3'd1, 5'd5, 1'b0);
      2: prog[0] = i_alu(3'd0, 3'd2, 3'd0, 3'd0, 5'd0, 1'b0);
      3: begin
           prog[0] = i_alu(3'd1, 3'd0, 3'd0, 3'd0, 5'd0, 1'b1);
           prog[1] = i_alu(3'd1, 3'd0, 3'd0, 3'd0, 5'd0, 1'b0);
         end
      4: begin
           prog[0] = i_br(3'd0, 1'b0, 1'b0, 18'h2);
           prog[1] = i_br(3'd0, 1'b0, 1'b0, 18'h2);
         end
      default: ;
    endcase
    run(dn, er);
    check({"R11 error ", tag}, er, 1);
    check({"R11 done ", tag}, dn, kind == 3);
    @(negedge clk);
    check({"R11 stopped ", tag}, busy, 0);
    cmp_log({"R11 ", tag});
  endtask

  bit wd_fired = 0;
  initial begin
    #(20 * 150000);
    wd_fired = 1;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) begin prog[i] = '0; q[i] = '0; end
    repeat (3) @(negedge clk);
    check("R1 reset busy", busy, 0);
    check("R1 reset done", done, 0);
    check("R11 reset error", error, 0);
    check("R7 reset mw_valid", mw_valid, 0);
    check("R3 reset rd_valid", rd_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 no pop when idle", prm_ready, 0);
    t_basic;
    t_alu;
    t_bits;
    t_rops;
    t_branch;
    t_exit_slot;
    t_err("bad opcode", 0);
    t_err("bad alu", 1);
    t_err("empty fetch", 2);
    t_err("leftover", 3);
    t_err("branch in slot", 4);
    t_err("empty start", 5);
    t_basic;   // R11 error cleared by a new start
    if (!wd_fired) begin
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule